// File: doc/BRIEF.md
# Deterministic ESOP Test Pattern Generator

This block produces a fixed, circuit-independent test sequence for an easily testable two-level AND-EXOR network with `N_IN` data inputs. It drives two control lines (`sel_a`, `sel_b`) that steer the extra test gates of the network under test, and `N_IN` data lines. One start pulse produces exactly `N_IN + 6` vectors on consecutive clock cycles. `vec_valid` marks each of these cycles. After the last vector the block raises `done` and holds steady until a new start arrives.

The sequence has two phases. First, a three-flop state machine sets out six fixed vectors. Each pairs one control setting with data that is either all zeros or all ones. Next, a chain of data flip-flops, one per input, is already filled with ones. A single zero is shifted into bit 0, and the zero walks one position per clock until it leaves the top bit. No seed or feedback polynomial is needed. The chain grows by one flop for each extra input.

Top module: `esop_pattern_gen`

## Requirements
- R1: During and after synchronous active-low reset, and until a start is accepted, the outputs are `sel_a`=0, `sel_b`=0, `data_o` all zeros, `vec_valid`=0 and `done`=0.
- R2: A `start` seen at a clock edge while idle or done puts the first vector on the outputs right after that edge. `vec_valid` is then 1 for exactly `N_IN + 6` consecutive cycles.
- R3: The first six vectors, as (`sel_a`, `sel_b`, `data_o`), come in this order: (0,0,zeros), (0,0,ones), (0,1,zeros), (0,1,ones), (1,0,zeros), (1,1,ones).
- R4: Vector 7+k, for k = 0..`N_IN`-1, has `sel_a`=0 and `sel_b`=0. In `data_o`, bit k is 0 and every other bit is 1. `data_o[0]` is the first data input.
- R5: In the cycle after the last vector, `done`=1, `vec_valid`=0, `sel_a`=`sel_b`=0 and `data_o` is all ones. This state holds while `start` stays low.
- R6: `start` asserted while a sequence is running has no effect: the running sequence continues unchanged.
- R7: `start` while `done` is high begins a new, identical sequence in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a sequence (sampled at the rising edge) |
| sel_a | output | 1 | First test-control line |
| sel_b | output | 1 | Second test-control line |
| data_o | output | N_IN | Data pattern; bit 0 is the first input |
| vec_valid | output | 1 | Current outputs are a test vector |
| done | output | 1 | Sequence finished; outputs held |

## Verification
The assertions check several properties on every cycle. The chain never holds more than one zero. The fixed states advance by exactly one per clock. Both control lines stay low while the zero walks. `done` excludes `vec_valid`, and the done state stays frozen while no start arrives. The exact order and count of the vectors, including where the zero sits in each cycle, are shown only by the bench. It compares every cycle against a position-counting reference. It also covers a start held through a whole run, a restart from the done state, and a reset applied mid-sequence.

// File: rtl/esop_tpg_pkg.sv
// Package: shared state type and fixed-vector decode for the ESOP pattern
// generator. Assumes the three-bit encoding below, where the six fixed
// states are consecutive so that the sequencer steps them by increment.
package esop_tpg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_V1   = 3'd1,
        ST_V2   = 3'd2,
        ST_V3   = 3'd3,
        ST_V4   = 3'd4,
        ST_V5   = 3'd5,
        ST_V6   = 3'd6,
        ST_HALT = 3'd7
    } tpg_state_e;

    // Fixed vector: two control bits plus a flag selecting all-ones data.
    typedef struct packed {
        logic ctl_a;
        logic ctl_b;
        logic ones;
    } fixed_vec_t;

    function automatic fixed_vec_t fixed_lookup(input tpg_state_e st);
        fixed_vec_t v;
        v = '0;
        case (st)
            ST_V1:   v = '{ctl_a: 1'b0, ctl_b: 1'b0, ones: 1'b0};
            ST_V2:   v = '{ctl_a: 1'b0, ctl_b: 1'b0, ones: 1'b1};
            ST_V3:   v = '{ctl_a: 1'b0, ctl_b: 1'b1, ones: 1'b0};
            ST_V4:   v = '{ctl_a: 1'b0, ctl_b: 1'b1, ones: 1'b1};
            ST_V5:   v = '{ctl_a: 1'b1, ctl_b: 1'b0, ones: 1'b0};
            ST_V6:   v = '{ctl_a: 1'b1, ctl_b: 1'b1, ones: 1'b1};
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/esop_tpg_ctrl.sv
// Sequencer: three-flop state machine that steps through the six fixed
// vectors, then parks in HALT while the data chain walks its zero.
// Assumes chain_clear is high only when the chain holds no zero.
module esop_tpg_ctrl
    import esop_tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       chain_clear,
    output tpg_state_e state,
    output logic       chain_set,
    output logic       chain_shift,
    output logic       chain_bit
);

    tpg_state_e state_nx;
    logic       can_launch;

    // Launch is allowed from idle, or from HALT once the walk has finished.
    assign can_launch = (state == ST_IDLE) || (state == ST_HALT && chain_clear);

    // Next-state selection.
    always_comb begin
        state_nx = state;
        if (can_launch && start) begin
            state_nx = ST_V1;
        end else begin
            case (state)
                ST_V1:   state_nx = ST_V2;
                ST_V2:   state_nx = ST_V3;
                ST_V3:   state_nx = ST_V4;
                ST_V4:   state_nx = ST_V5;
                ST_V5:   state_nx = ST_V6;
                ST_V6:   state_nx = ST_HALT;
                default: state_nx = state;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Chain controls: preload ones early, inject the zero on V6, then shift ones.
    always_comb begin
        chain_set   = (state != ST_V6) && (state != ST_HALT);
        chain_shift = (state == ST_V6) || (state == ST_HALT);
        chain_bit   = (state != ST_V6);
    end

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_V1));   // R2

    AST_FIXED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_V1, ST_V2, ST_V3, ST_V4, ST_V5})
        |=> (state == tpg_state_e'($past(state) + 3'd1)));    // R3

    AST_RUN_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !chain_clear) |=> (state == ST_HALT)); // R6

endmodule

// File: rtl/esop_tpg_chain.sv
// Data chain: one flop per data input. It is set to all ones in parallel,
// then shifted from bit 0 upward. Assumes set and shift never overlap.
// Any width of one or more is supported.
module esop_tpg_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_all,
    input  logic             shift_en,
    input  logic             shift_bit,
    output logic [WIDTH-1:0] bits,
    output logic             all_ones
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic feed;
        if (i == 0) begin : g_head
            assign feed = shift_bit;
        end else begin : g_body
            assign feed = bits[i-1];
        end

        // One cell: reset or set to 1, otherwise take the neighbour when shifting.
        always_ff @(posedge clk) begin
            if (!rst_n || set_all) bits[i] <= 1'b1;
            else if (shift_en)     bits[i] <= feed;
        end
    end

    assign all_ones = &bits;

    AST_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~bits) <= 1));                            // R4

endmodule

// File: rtl/esop_tpg_outmux.sv
// Output stage: turns sequencer state and chain contents into the
// control lines, data pattern and the valid/done flags. Purely combinational.
module esop_tpg_outmux
    import esop_tpg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  tpg_state_e       state,
    input  logic [WIDTH-1:0] chain,
    input  logic             chain_clear,
    output logic             sel_a,
    output logic             sel_b,
    output logic [WIDTH-1:0] data_o,
    output logic             vec_valid,
    output logic             done
);

    fixed_vec_t fv;

    // Decode the fixed vector for the current state.
    assign fv = fixed_lookup(state);

    // Select between fixed patterns, the walking chain and the idle value.
    always_comb begin
        sel_a     = 1'b0;
        sel_b     = 1'b0;
        data_o    = '0;
        vec_valid = 1'b0;
        done      = 1'b0;
        case (state)
            ST_IDLE: ;
            ST_HALT: begin
                data_o    = chain;
                vec_valid = !chain_clear;
                done      = chain_clear;
            end
            default: begin
                sel_a     = fv.ctl_a;
                sel_b     = fv.ctl_b;
                data_o    = {WIDTH{fv.ones}};
                vec_valid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/esop_pattern_gen.sv
// Top: deterministic test pattern generator for a two-level AND-EXOR
// network with N_IN data inputs. One start yields N_IN+6 vectors, after
// which done is raised and the outputs hold. Requires N_IN >= 1.
module esop_pattern_gen
    import esop_tpg_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            sel_a,
    output logic            sel_b,
    output logic [N_IN-1:0] data_o,
    output logic            vec_valid,
    output logic            done
);

    tpg_state_e      state;
    logic            chain_set;
    logic            chain_shift;
    logic            chain_bit;
    logic            chain_clear;
    logic [N_IN-1:0] chain;

    esop_tpg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .chain_clear (chain_clear),
        .state       (state),
        .chain_set   (chain_set),
        .chain_shift (chain_shift),
        .chain_bit   (chain_bit)
    );

    esop_tpg_chain #(.WIDTH(N_IN)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_all   (chain_set),
        .shift_en  (chain_shift),
        .shift_bit (chain_bit),
        .bits      (chain),
        .all_ones  (chain_clear)
    );

    esop_tpg_outmux #(.WIDTH(N_IN)) u_out (
        .state       (state),
        .chain       (chain),
        .chain_clear (chain_clear),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .data_o      (data_o),
        .vec_valid   (vec_valid),
        .done        (done)
    );

    AST_WALK_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (!sel_a && !sel_b));          // R4

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vec_valid && (&data_o)));                  // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(data_o)));      // R5

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (vec_valid && !sel_a && !sel_b && data_o == '0)); // R7

endmodule

// File: tb/esop_pattern_gen_tb.sv
module esop_pattern_gen_tb;

    localparam int N = 8;
    localparam int LAST = N + 6;   // position index meaning "done"

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sel_a, sel_b, vec_valid, done;
    logic [N-1:0] data_o;

    int checks = 0;
    int fails  = 0;
    int pos    = -1;   // -1 idle, 0..LAST-1 vector index, LAST done
    int cycles = 0;
    int valid_run = 0;

    always #4 clk = ~clk;   // 125 MHz

    esop_pattern_gen #(.N_IN(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sel_a(sel_a), .sel_b(sel_b), .data_o(data_o),
        .vec_valid(vec_valid), .done(done)
    );

    // Reference position tracker, derived from the sequence rules.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n)                                   pos <= -1;
        else if ((pos == -1 || pos == LAST) && start) pos <= 0;
        else if (pos >= 0 && pos < LAST)              pos <= pos + 1;
    end

    function automatic logic [N+3:0] expect_at(input int p);
        logic a, b, v, d;
        logic [N-1:0] x;
        a = 0; b = 0; v = 0; d = 0; x = '0;
        if (p >= 0 && p < 6) begin
            v = 1;
            case (p)
                0: begin a = 0; b = 0; x = '0; end
                1: begin a = 0; b = 0; x = '1; end
                2: begin a = 0; b = 1; x = '0; end
                3: begin a = 0; b = 1; x = '1; end
                4: begin a = 1; b = 0; x = '0; end
                default: begin a = 1; b = 1; x = '1; end
            endcase
        end else if (p >= 6 && p < LAST) begin
            v = 1;
            x = '1;
            x[p-6] = 1'b0;
        end else if (p == LAST) begin
            d = 1;
            x = '1;
        end
        return {a, b, v, d, x};
    endfunction

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        logic [N+3:0] e, got;
        string tag;
        e   = expect_at(pos);
        got = {sel_a, sel_b, vec_valid, done, data_o};
        if (pos < 0)         tag = "R1";
        else if (pos < 6)    tag = "R3";
        else if (pos < LAST) tag = "R4";
        else                 tag = "R5";
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s pos=%0d actual a=%b b=%b v=%b d=%b x=%b expected a=%b b=%b v=%b d=%b x=%b",
                     tag, pos, got[N+3], got[N+2], got[N+1], got[N], got[N-1:0],
                     e[N+3], e[N+2], e[N+1], e[N], e[N-1:0]);
        end
        if (vec_valid === 1'b1) valid_run++;
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: count valid cycles of one run and compare with N+6.
    task automatic check_run_length(input string tag);
        checks++;
        if (valid_run != N + 6) begin
            fails++;
            $display("FAIL %s run length actual=%0d expected=%0d", tag, valid_run, N + 6);
        end
    endtask

    initial begin
        wait_cycles(3);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(3);                       // R1: idle after reset

        // Plain run (R2, R3, R4, R5)
        valid_run = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_cycles(N + 10);
        check_run_length("R2");

        // R6: start held high for the whole run after launch; R7 relaunch at done
        valid_run = 0;
        start = 1'b1;
        wait_cycles(N + 6);
        start = 1'b0;
        wait_cycles(3);
        check_run_length("R6");

        // R7: pulse start while done, sequence repeats identically
        valid_run = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_cycles(N + 8);
        check_run_length("R7");

        // Reset mid-run, then check idle (R1) and a fresh run
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_cycles(4);
        rst_n = 1'b0; wait_cycles(2); rst_n = 1'b1;
        wait_cycles(3);
        valid_run = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_cycles(N + 8);
        check_run_length("R2");

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles > 5000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d cycles expected<5000", cycles);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule